// File: doc/BRIEF.md
# Triangular Toeplitz and Diagonal-Scaled Stream Generator

This block turns one vector of N windowed samples v(0) … v(N-1) into two serial operand streams for a downstream linear matrix-multiply array. The first stream is an N×N upper-triangular Toeplitz matrix U, sent row by row, one element per clock. The second stream carries the same elements, each multiplied by the sample that sits on the diagonal of D for the current row. Read in row-major order, this gives the transposed-U times D product in column-major order, which is the order the array expects for its A operand.

A one-cycle start pulse in the idle state copies the sample vector into an internal bank and launches a frame. The frame then emits exactly N² elements on consecutive clocks. The two streams share one valid flag and one last flag. The product is kept at the full double width, and no rounding is applied. A sequencer with two states drives the frame:
- IDLE goes to RUN on start.
- RUN stays in RUN until the element at row N-1, column N-1 has been issued, then returns to IDLE.
- A start seen in RUN is ignored.

Top module: `tpz_scale_stream`

## Requirements
- R1: While reset is held and after it is released, with no start yet, out_valid and out_last are 0 and both data outputs are 0.
- R2: A start pulse sampled in IDLE makes out_valid high from the next clock edge for exactly N² consecutive cycles, then low.
- R3: Element k of a frame (k = i·N + j, row i, column j, both from 0) on out_u equals v(N-1-(j-i)) when j ≥ i.
- R4: Elements with j < i are exactly 0 on both out_u and out_scaled.
- R5: out_scaled equals the signed product out_u · v(i), 2·W bits wide, exact for every pair of signed W-bit values.
- R6: out_u and out_scaled belong to the same element in every valid cycle.
- R7: out_last is high only on the final (N²-th) element of a frame, and only together with out_valid.
- R8: A start that arrives while a frame is running, including on its last element, neither restarts nor lengthens that frame.
- R9: The samples are taken from samp_flat (v(k) in bits k·W+W-1 … k·W, two's complement) at the accepted start only. Later changes to samp_flat do not affect the running frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches a frame when sampled in IDLE |
| samp_flat | input | N*W | Packed signed samples, v(k) at bits k·W upward |
| out_u | output | W | Unscaled Toeplitz element (B operand) |
| out_scaled | output | 2*W | Element times diagonal sample (A operand) |
| out_valid | output | 1 | Both data outputs hold a frame element |
| out_last | output | 1 | Final element of the frame |

## Verification
A ramp vector makes every Toeplitz position distinct, so an index error along a row or a missing shift shows up as a wrong value. A vector with one nonzero sample in the top slot leaves only the main diagonal set, which separates the zero fill below the diagonal from the shifted copies above it. Signed extremes (-128, 127, -1) test the sign handling and the full product width. A start held high across frames, and a sample vector changed in the middle of a frame, check that starts are ignored while running and that the samples are captured only when a frame is accepted.

// File: rtl/tpz_pkg.sv
package tpz_pkg;
    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;
endpackage

// File: rtl/tpz_addr_seq.sv
module tpz_addr_seq
    import tpz_pkg::*;
#(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          capture,
    output logic          run,
    output logic          final_pos,
    output logic [IW-1:0] row,
    output logic [IW-1:0] col
);
    localparam logic [IW-1:0] LAST_IDX = IW'(N - 1);

    seq_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: if (start)     state_d = SEQ_RUN;
            SEQ_RUN:  if (final_pos) state_d = SEQ_IDLE;
            default:                 state_d = SEQ_IDLE;
        endcase
    end

    // outputs of the sequencer
    always_comb begin
        capture   = 1'b0;
        run       = 1'b0;
        final_pos = 1'b0;
        unique case (state_q)
            SEQ_IDLE: capture = start;
            SEQ_RUN: begin
                run       = 1'b1;
                final_pos = (row == LAST_IDX) && (col == LAST_IDX);
            end
            default: ;
        endcase
    end

    // row / column counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row <= '0;
            col <= '0;
        end else if (capture) begin
            row <= '0;
            col <= '0;
        end else if (run) begin
            if (col == LAST_IDX) begin
                col <= '0;
                if (!final_pos) row <= row + 1'b1;
            end else begin
                col <= col + 1'b1;
            end
        end
    end

    // R3: after the last column of a row the scan moves to column 0 of the next row
    assert_row_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_RUN && col == LAST_IDX && !final_pos)
            |=> (col == '0 && row == $past(row) + 1'b1));

    // R8: a running frame is not cut short, whatever start does
    assert_frame_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_RUN && !final_pos) |=> (state_q == SEQ_RUN));

    // R8: the end of a frame always returns to idle, even with start high
    assert_frame_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        final_pos |=> (state_q == SEQ_IDLE));
endmodule

// File: rtl/tpz_elem_sel.sv
module tpz_elem_sel #(
    parameter int N  = 4,
    parameter int W  = 8,
    parameter int IW = 2
) (
    input  logic signed [W-1:0] v_i [N],
    input  logic        [IW-1:0] row,
    input  logic        [IW-1:0] col,
    output logic signed [W-1:0] elem,
    output logic signed [W-1:0] diag
);
    localparam logic [IW-1:0] LAST_IDX = IW'(N - 1);

    logic [IW-1:0] offset;
    logic [IW-1:0] tap;

    always_comb begin
        offset = col - row;
        tap    = LAST_IDX - offset;
        if (col >= row) elem = v_i[tap];
        else            elem = '0;
        diag = v_i[row];
    end
endmodule

// File: rtl/tpz_scaler.sv
module tpz_scaler #(
    parameter int W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic                  in_last,
    input  logic signed [W-1:0]   elem,
    input  logic signed [W-1:0]   diag,
    output logic signed [W-1:0]   u_o,
    output logic signed [2*W-1:0] p_o,
    output logic                  valid_o,
    output logic                  last_o
);
    logic signed [2*W-1:0] prod;

    always_comb prod = elem * diag;

    // single multiplier stage, raw element delayed alongside it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            u_o     <= '0;
            p_o     <= '0;
            valid_o <= 1'b0;
            last_o  <= 1'b0;
        end else begin
            valid_o <= in_valid;
            last_o  <= in_valid && in_last;
            if (in_valid) begin
                u_o <= elem;
                p_o <= prod;
            end else begin
                u_o <= '0;
                p_o <= '0;
            end
        end
    end

    // R4: a zero element yields an exact zero product
    assert_zero_prod_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && u_o == '0) |-> (p_o == '0));

    // R7: last only with valid
    assert_last_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    // R2 / R7: a frame only stops after its last element
    assert_valid_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(valid_o) |-> $past(last_o));

    // R1: idle outputs are clean
    assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (u_o == '0 && p_o == '0 && !last_o));
endmodule

// File: rtl/tpz_scale_stream.sv
module tpz_scale_stream #(
    parameter int N = 4,
    parameter int W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [N*W-1:0]        samp_flat,
    output logic signed [W-1:0]   out_u,
    output logic signed [2*W-1:0] out_scaled,
    output logic                  out_valid,
    output logic                  out_last
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic              capture, run, final_pos;
    logic [IW-1:0]     row, col;
    logic signed [W-1:0] v_q [N];
    logic signed [W-1:0] elem, diag;

    tpz_addr_seq #(.N(N), .IW(IW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .capture   (capture),
        .run       (run),
        .final_pos (final_pos),
        .row       (row),
        .col       (col)
    );

    // sample bank, loaded only when a frame is accepted
    for (genvar k = 0; k < N; k++) begin : g_bank
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       v_q[k] <= '0;
            else if (capture) v_q[k] <= samp_flat[k*W +: W];
        end
    end

    tpz_elem_sel #(.N(N), .W(W), .IW(IW)) u_sel (
        .v_i  (v_q),
        .row  (row),
        .col  (col),
        .elem (elem),
        .diag (diag)
    );

    tpz_scaler #(.W(W)) u_scl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (run),
        .in_last  (final_pos),
        .elem     (elem),
        .diag     (diag),
        .u_o      (out_u),
        .p_o      (out_scaled),
        .valid_o  (out_valid),
        .last_o   (out_last)
    );

    // R9: the bank holds still for the whole frame
    assert_bank_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> $stable(v_q[0]));
endmodule

// File: tb/tb_tpz_scale_stream.sv
module tb_tpz_scale_stream;
    localparam int N = 4;
    localparam int W = 8;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  start = 1'b0;
    logic [N*W-1:0]        samp_flat = '0;
    logic signed [W-1:0]   out_u;
    logic signed [2*W-1:0] out_scaled;
    logic                  out_valid;
    logic                  out_last;

    tpz_scale_stream #(.N(N), .W(W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .samp_flat(samp_flat),
        .out_u(out_u), .out_scaled(out_scaled),
        .out_valid(out_valid), .out_last(out_last)
    );

    always #10 clk = ~clk; // 50 MHz

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    // reference model state
    int q_u[$], q_p[$], q_l[$], q_r[$], q_c[$];
    int exp_v = 0, exp_u = 0, exp_p = 0, exp_l = 0, exp_r = 0, exp_c = 0;

    task automatic chk(string req, string what, int act, int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // behavioural model: what appears on the outputs after each edge
    always @(posedge clk) begin
        if (!rst_n) begin
            q_u.delete(); q_p.delete(); q_l.delete(); q_r.delete(); q_c.delete();
            exp_v = 0; exp_u = 0; exp_p = 0; exp_l = 0;
        end else begin
            bit idle_before;
            idle_before = (q_u.size() == 0);
            if (!idle_before) begin
                exp_v = 1;
                exp_u = q_u.pop_front(); exp_p = q_p.pop_front();
                exp_l = q_l.pop_front(); exp_r = q_r.pop_front();
                exp_c = q_c.pop_front();
            end else begin
                exp_v = 0; exp_u = 0; exp_p = 0; exp_l = 0;
            end
            if (start && idle_before) begin
                int cap[N];
                for (int k = 0; k < N; k++) cap[k] = $signed(samp_flat[k*W +: W]);
                for (int i = 0; i < N; i++) begin
                    for (int j = 0; j < N; j++) begin
                        int u;
                        u = (j >= i) ? cap[N-1-(j-i)] : 0;
                        q_u.push_back(u);
                        q_p.push_back(u * cap[i]);
                        q_l.push_back((i == N-1 && j == N-1) ? 1 : 0);
                        q_r.push_back(i);
                        q_c.push_back(j);
                    end
                end
            end
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2", "valid", int'(out_valid), exp_v);
            chk("R7", "last", int'(out_last), exp_l);
            if (exp_v != 0) begin
                if (exp_c < exp_r)
                    chk("R4", "u below diagonal", int'(out_u), exp_u);
                else
                    chk("R3", "u element", int'(out_u), exp_u);
                chk("R5 R6", "scaled element", int'(out_scaled), exp_p);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic set_samples(int a0, int a1, int a2, int a3);
        samp_flat[0*W +: W] = W'(a0);
        samp_flat[1*W +: W] = W'(a1);
        samp_flat[2*W +: W] = W'(a2);
        samp_flat[3*W +: W] = W'(a3);
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_idle();
        repeat (N*N + 3) @(negedge clk);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "valid in reset", int'(out_valid), 0);
        chk("R1", "last in reset", int'(out_last), 0);
        chk("R1", "u in reset", int'(out_u), 0);
        chk("R1", "scaled in reset", int'(out_scaled), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "valid after reset", int'(out_valid), 0);

        // R3 R5: ramp, every position distinct
        set_samples(1, 2, 3, 4);
        pulse_start();
        wait_idle();

        // R4: only v(N-1) nonzero leaves the main diagonal
        set_samples(0, 0, 0, 5);
        pulse_start();
        wait_idle();

        // R5: signed extremes
        set_samples(-128, 127, -1, -128);
        pulse_start();
        wait_idle();

        // R9: change samples in mid-frame
        set_samples(7, -3, 11, -9);
        pulse_start();
        repeat (5) @(negedge clk);
        set_samples(100, 100, 100, 100);
        wait_idle();

        // R8: start held high across frames, also on the last element
        set_samples(-5, 6, -7, 8);
        @(negedge clk); start = 1'b1;
        repeat (2*N*N + 3) @(negedge clk);
        start = 1'b0;
        set_samples(3, -2, 1, 0);
        wait_idle();
        wait_idle();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule